// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Reset Flag

This block is a watchdog that always runs. It counts a slow prescaled tick, so its period follows the current power mode. A two-bit interval select picks one of four timeout lengths. When the timeout expires, the block sets a timeout flag. The flag also drives an interrupt when the interrupt enable is high.

If the reset function is armed, the same expiry opens a grace window counted on the undivided clock. A one-cycle reset pulse leaves the block only if software does not restart the timer before the window closes.

A reset caused by the watchdog sets a sticky cause flag, which outlives that reset so software can find out why the chip restarted. The watchdog reset does not disarm the block: its counter simply begins again from zero. Only the power-fail reset (the block's own reset input) clears every flag and disarms the reset function.

Top module: `wdog_two_stage`

## Requirements
- R1: The timeout flag rises on the 2^(BASE_LOG2 + STEP_LOG2*ival_sel)-th tick after a restart. With the default parameters, codes 0, 1, 2 and 3 give 2^17, 2^20, 2^23 and 2^26 ticks.
- R2: The counter advances only in cycles where `tick` is high.
- R3: A timeout sets `tmo_flag` whatever the value of `irq_en`. `irq` is high only while both `tmo_flag` and `irq_en` are high.
- R4: While the reset function is disarmed, no `wd_rst` pulse is produced. The counter keeps running, and the next timeout follows one period after the previous one.
- R5: While the reset function is armed, `wd_rst` goes high for exactly one cycle, GRACE_CLKS clock cycles after the cycle in which `tmo_flag` rose (default 512).
- R6: A `restart` pulse inside the grace window cancels the pending reset. A `restart` also clears the counter.
- R7: A watchdog reset clears `tmo_flag`, sets `cause_flag`, restarts the counter from zero and leaves the reset function armed.
- R8: `cause_flag` is set only by a watchdog reset and is cleared only by `cause_clr` or by `rst_n`. When a set and a clear fall in the same cycle, the set wins.
- R9: `tmo_clr` clears `tmo_flag`. When a timeout and `tmo_clr` fall in the same cycle, the flag ends up set.
- R10: While `rst_n` is low, `tmo_flag`, `cause_flag`, `wd_rst` and `rst_en_o` are 0, and the counter is cleared.
- R11: A cycle with `rst_en_we` high loads `rst_en_wdata` into the reset enable. The current value of the enable is visible on `rst_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-fail reset, asynchronous |
| tick | input | 1 | Prescaled count enable |
| ival_sel | input | 2 | Timeout interval select |
| rst_en_we | input | 1 | Write strobe for the reset enable |
| rst_en_wdata | input | 1 | New value for the reset enable |
| irq_en | input | 1 | Interrupt enable |
| restart | input | 1 | Restart strobe: clears the counter and cancels a pending reset |
| tmo_clr | input | 1 | Software clear of the timeout flag |
| cause_clr | input | 1 | Software clear of the reset-cause flag |
| wd_rst | output | 1 | One-cycle watchdog reset pulse |
| irq | output | 1 | Watchdog interrupt |
| tmo_flag | output | 1 | Timeout / interrupt status flag |
| cause_flag | output | 1 | Sticky flag showing that the watchdog caused a reset |
| rst_en_o | output | 1 | Current reset enable |

## Verification
The hardest conditions to reach are the same-cycle collisions. One is a software clear landing on the exact cycle of a timeout. The other is a cause clear landing on the exact cycle the reset pulse fires. The bench reaches both by restarting the counter at a known edge, holding `tick` high and counting clock cycles. This lets it place each clear strobe on the precise edge where the hardware sets the flag. The grace-window cancel is reached the same way, with a `restart` pulse a few cycles into the window. A second timeout then has to stay too far away to fire inside the observation window.

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int BASE_LOG2  = 17,
  parameter int STEP_LOG2  = 3,
  parameter int GRACE_CLKS = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] ival_sel,
  input  logic       rst_en_we,
  input  logic       rst_en_wdata,
  input  logic       irq_en,
  input  logic       restart,
  input  logic       tmo_clr,
  input  logic       cause_clr,
  output logic       wd_rst,
  output logic       irq,
  output logic       tmo_flag,
  output logic       cause_flag,
  output logic       rst_en_o
);
  localparam int CNT_W = BASE_LOG2 + 3 * STEP_LOG2;
  localparam int GW    = $clog2(GRACE_CLKS);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   lim;
  logic [7:0]       sh;
  logic [GW-1:0]    gcnt;
  logic             pend, rst_en_q, fire, tmo_evt, hit;

  assign sh      = 8'(BASE_LOG2) + 8'(STEP_LOG2) * {6'd0, ival_sel};
  assign lim     = {{CNT_W{1'b0}}, 1'b1} << sh;
  assign hit     = ({1'b0, cnt} >= lim - 1'b1);
  assign fire    = pend & rst_en_q & ~restart & (gcnt == GW'(GRACE_CLKS - 1));
  assign tmo_evt = tick & hit & ~restart & ~fire;
  assign irq     = tmo_flag & irq_en;
  assign rst_en_o = rst_en_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            cnt <= '0;
    else if (restart | fire) cnt <= '0;
    else if (tick)         cnt <= hit ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend <= 1'b0;
      gcnt <= '0;
    end else if (restart | fire | ~rst_en_q) begin
      pend <= 1'b0;
      gcnt <= '0;
    end else if (tmo_evt & ~pend) begin
      pend <= 1'b1;
      gcnt <= '0;
    end else if (pend) begin
      gcnt <= gcnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         rst_en_q <= 1'b0;
    else if (rst_en_we) rst_en_q <= rst_en_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       tmo_flag <= 1'b0;
    else if (fire)    tmo_flag <= 1'b0;
    else if (tmo_evt) tmo_flag <= 1'b1;
    else if (tmo_clr) tmo_flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         cause_flag <= 1'b0;
    else if (fire)      cause_flag <= 1'b1;
    else if (cause_clr) cause_flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wd_rst <= 1'b0;
    else        wd_rst <= fire;
endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk (
  input logic clk,
  input logic rst_n,
  input logic wd_rst,
  input logic tmo_flag,
  input logic cause_flag,
  input logic restart,
  input logic rst_en_o
);
  p_pulse_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |=> !wd_rst);
  p_cause_with_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |-> cause_flag);
  p_flag_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |-> !tmo_flag);
  p_restart_cancels_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !wd_rst);
  p_no_rst_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_en_o |=> !wd_rst);
  p_cause_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause_flag) |-> wd_rst);
endmodule

bind wdog_two_stage wdog_two_stage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wd_rst(wd_rst), .tmo_flag(tmo_flag),
  .cause_flag(cause_flag), .restart(restart), .rst_en_o(rst_en_o)
);

// File: tb/wdog_two_stage_tb.sv
module wdog_two_stage_tb;
  localparam int GR = 16;
  logic clk = 0, rst_n = 0, tick = 0, rst_en_we = 0, rst_en_wdata = 0;
  logic irq_en = 0, restart = 0, tmo_clr = 0, cause_clr = 0;
  logic [1:0] ival_sel = 0;
  logic wd_rst, irq, tmo_flag, cause_flag, rst_en_o;
  int checks = 0, errs = 0, rst_seen = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdog_two_stage #(.BASE_LOG2(3), .STEP_LOG2(1), .GRACE_CLKS(GR)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ival_sel(ival_sel),
    .rst_en_we(rst_en_we), .rst_en_wdata(rst_en_wdata), .irq_en(irq_en),
    .restart(restart), .tmo_clr(tmo_clr), .cause_clr(cause_clr),
    .wd_rst(wd_rst), .irq(irq), .tmo_flag(tmo_flag),
    .cause_flag(cause_flag), .rst_en_o(rst_en_o));

  always @(negedge clk) if (wd_rst) rst_seen++;

  localparam int NV = 6;
  localparam int V_SEL[NV] = '{0, 1, 2, 3, 0, 1};
  localparam int V_ALT[NV] = '{0, 0, 0, 0, 1, 1};
  localparam int V_EXP[NV] = '{8, 16, 32, 64, 15, 31};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_restart();
    @(negedge clk); restart = 1; tmo_clr = 1;
    @(negedge clk); restart = 0; tmo_clr = 0;
  endtask

  task automatic measure(input bit alt, output int n);
    n = 0; tick = 1;
    while (!tmo_flag && n < 1000) begin
      @(negedge clk); n++;
      if (alt) tick = ~tick;
    end
    tick = 1;
  endtask

  task automatic wr_en(input bit v);
    @(negedge clk); rst_en_we = 1; rst_en_wdata = v;
    @(negedge clk); rst_en_we = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int n, m, base;
    repeat (3) @(negedge clk);
    chk(!tmo_flag && !cause_flag && !wd_rst && !rst_en_o && !irq, "R10 reset state", 0, 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      ival_sel = 2'(V_SEL[i]);
      do_restart();
      measure(V_ALT[i] != 0, n);
      chk(n == V_EXP[i], V_ALT[i] != 0 ? "R2 half-rate tick period" : "R1 interval period", n, V_EXP[i]);
      chk(!irq, "R3 irq masked", irq, 0);
    end

    @(negedge clk); irq_en = 1;
    @(negedge clk);
    chk(irq === 1'b1, "R3 irq with enable", irq, 1);
    tmo_clr = 1; @(negedge clk); tmo_clr = 0;
    chk(!tmo_flag && !irq, "R9 software clear", tmo_flag, 0);
    irq_en = 0;

    ival_sel = 0;
    wr_en(1);
    chk(rst_en_o === 1'b1, "R11 enable write", rst_en_o, 1);
    do_restart();
    measure(0, n);
    m = 0;
    while (!wd_rst && m < 200) begin @(negedge clk); m++; end
    chk(m == GR, "R5 grace length", m, GR);
    chk(cause_flag && !tmo_flag, "R7 flags at reset", {cause_flag, tmo_flag}, 2);
    measure(0, n);
    chk(n == 8, "R7 counter restarted", n, 8);
    chk(rst_seen == 1, "R5 single pulse", rst_seen, 1);
    chk(rst_en_o === 1'b1, "R7 enable kept", rst_en_o, 1);

    repeat (4) @(negedge clk);
    base = rst_seen;
    restart = 1; @(negedge clk); restart = 0;
    repeat (GR + 4) @(negedge clk);
    chk(rst_seen == base, "R6 restart cancels", rst_seen - base, 0);

    wr_en(0);
    cause_clr = 1; @(negedge clk); cause_clr = 0;
    chk(!cause_flag, "R8 software clear", cause_flag, 0);

    base = rst_seen;
    do_restart();
    measure(0, n);
    chk(n == 8, "R4 period disarmed", n, 8);
    tmo_clr = 1; @(negedge clk); tmo_clr = 0;
    measure(0, n);
    chk(n == 7, "R4 counter kept running", n, 7);
    repeat (GR + 4) @(negedge clk);
    chk(rst_seen == base, "R4 no reset when disarmed", rst_seen - base, 0);

    do_restart();
    tick = 1;
    repeat (7) @(negedge clk);
    tmo_clr = 1;
    @(negedge clk); tmo_clr = 0;
    chk(tmo_flag === 1'b1, "R9 set beats clear", tmo_flag, 1);
    tmo_clr = 1; @(negedge clk); tmo_clr = 0;
    chk(!tmo_flag, "R9 clear after", tmo_flag, 0);

    wr_en(1);
    do_restart();
    measure(0, n);
    repeat (GR - 1) @(negedge clk);
    cause_clr = 1;
    @(negedge clk); cause_clr = 0;
    chk(wd_rst && cause_flag, "R8 set beats clear", {wd_rst, cause_flag}, 3);
    @(negedge clk);
    chk(cause_flag === 1'b1, "R8 sticky", cause_flag, 1);

    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk(!tmo_flag && !cause_flag && !wd_rst && !rst_en_o, "R10 power reset clears",
        {tmo_flag, cause_flag, rst_en_o}, 0);
    rst_n = 1;
    base = rst_seen;
    measure(0, n);
    chk(n == 8, "R10 counter cleared", n, 8);
    repeat (GR + 4) @(negedge clk);
    chk(rst_seen == base, "R10 reset disarmed", rst_seen - base, 0);

    finish_run();
  end
endmodule